// File: doc/BRIEF.md
# Serial Port with Two-Stage Baud Prescaler

This block is a byte-wide asynchronous serial transmitter and receiver behind a two-word register interface. Software sets an enable bit, a 3-bit coarse clock select and a 12-bit fine divider in the control word. It starts a frame by writing a byte to the data word. Once a frame has been received, the byte is read back from the data word.

Each bit on the line lasts a fixed number of clock cycles. That number is the product of two factors. The 3-bit select picks one of eight power-of-two ratios, and these ratios are not evenly spaced. The second factor is the 12-bit divider value plus one. The transmitter and the receiver each have their own prescaler. Each prescaler is restarted at the start of its own frame, so every bit period is exact in clock cycles. The receiver's prescaler runs at twice the rate, which lets it place its sample at the exact middle of each bit.

Frames are 8N1: one low start bit, eight data bits with the least significant bit first, and one high stop bit. When the line is idle it is high.

Top module: `serial_port`

## Requirements
- R1: After reset the control word reads 0, the data word reads 0, and `txd` is high.
- R2: While the enable bit is 0, a data-word write does not start a frame: `txd` stays high and busy stays 0. A frame arriving on `rxd` while the enable bit is 0 does not set the receive-available flag.
- R3: The select codes 0 to 7 pick clock ratios of 2, 4, 8, 64, 128, 1024, 2048 and 4096. One bit period equals the ratio multiplied by (divider + 1) clock cycles.
- R4: A data-word write made while the block is enabled and idle puts the start bit (low) on `txd` in the cycle after the write edge. The eight data bits follow with the least significant bit first, then one high stop bit.
- R5: The busy flag (control bit 31) rises at the write edge. It stays high for exactly 10 bit periods and then returns to 0.
- R6: A data-word write made while busy is 1 is ignored. The current frame is not changed and no second frame follows it.
- R7: The receiver finds a falling edge on the synchronized `rxd` and samples each bit at its middle. After a high stop bit it stores the byte and sets the receive-available flag (control bit 30).
- R8: A read of the data word returns the received byte in bits 7:0 and clears the receive-available flag.
- R9: A low pulse on `rxd` shorter than half a bit period is rejected. A frame whose stop bit is sampled low is discarded. Neither case sets the receive-available flag.
- R10: When the enable bit is cleared, `txd` is high and busy is 0 from the next cycle on. A receive in progress is dropped.
- R11: Address 0 is the control word and address 1 is the data word. The control word holds enable in bit 0, the select in bits 3:1 and the divider in bits 15:4. These fields read back as written, and bits 29:16 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of the data word clears the receive-available flag) |
| addr | input | 1 | Word select: 0 control, 1 data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The main pattern is a loopback from `txd` to `rxd`. A vector table covers all eight select codes with several divider values and bytes, including all-zero, all-one, single-bit and alternating bytes. Sampling every bit at the middle of the period the bench computes shows a wrong ratio, a wrong divider term or a wrong bit order. The same frame, read back on the receive side, tests the middle-of-bit sampling at both short and long periods. Directed patterns then separate the cases the receiver must reject (a short glitch and a low stop bit) from a clean frame driven by the bench. They also check that a second write during a frame changes neither the bits nor the frame length, and that clearing the enable bit ends a frame in progress.

// File: rtl/serial_port_pkg.sv
// Package: shared constants, types and the coarse prescaler map for the serial port.
// Assumes all coarse ratios are powers of two, so they are stored as shift amounts.
package serial_port_pkg;

    localparam int SEL_W      = 3;
    localparam int FRAME_BITS = 10;   // start + 8 data + stop

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Maps the coarse select code to log2 of its clock ratio.
    function automatic logic [3:0] coarse_shift(input logic [SEL_W-1:0] sel);
        logic [3:0] s;
        case (sel)
            3'd0:    s = 4'd1;
            3'd1:    s = 4'd2;
            3'd2:    s = 4'd3;
            3'd3:    s = 4'd6;
            3'd4:    s = 4'd7;
            3'd5:    s = 4'd10;
            3'd6:    s = 4'd11;
            default: s = 4'd12;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
// Module: coarse clock prescaler. It emits a one-cycle tick every 2^shift cycles, or every
// 2^(shift-1) cycles when HALF is set.
// Assumes CNT_W >= 12, so the largest ratio fits. A restart pulse realigns the phase to that cycle.
module baud_prescaler
    import serial_port_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter bit HALF  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [3:0]     base_shift;
    logic [3:0]     eff_shift;
    logic [CNT_W:0] lim_m1;
    logic [CNT_W-1:0] cnt_q;

    assign base_shift = coarse_shift(sel);

    // Chooses the full ratio or the half ratio.
    generate
        if (HALF) begin : g_half
            assign eff_shift = base_shift - 4'd1;
        end else begin : g_full
            assign eff_shift = base_shift;
        end
    endgenerate

    assign lim_m1 = ((CNT_W+1)'(1) << eff_shift) - (CNT_W+1)'(1);
    assign tick   = en && !restart && ({1'b0, cnt_q} == lim_m1);

    // Free-running division counter, cleared on reset, on disable and on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/serial_tx_path.sv
// Module: 8N1 transmitter. It accepts a byte when enabled and idle. Each bit lasts (div+1)
// prescaler ticks, and busy stays high until the stop bit has ended.
// Assumes the prescaler is restarted by the accept pulse, so the first bit is full length.
module serial_tx_path
    import serial_port_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [DIV_W-1:0]  div,
    input  logic              tick,
    output logic              accept,
    output logic              txd,
    output logic              busy
);

    localparam int IDX_W = $clog2(FRAME_BITS);

    logic [DATA_W:0]   shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DIV_W-1:0]  bcnt_q;
    logic              txd_q;
    logic              busy_q;

    assign accept = en && start && !busy_q;
    assign txd    = txd_q;
    assign busy   = busy_q;

    // Frame sequencer: loads the byte and shifts one bit out per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy_q  <= 1'b0;
            txd_q   <= 1'b1;
            idx_q   <= '0;
            bcnt_q  <= '0;
            shreg_q <= '1;
        end else if (accept) begin
            busy_q  <= 1'b1;
            txd_q   <= 1'b0;
            shreg_q <= {1'b1, byte_in};
            idx_q   <= '0;
            bcnt_q  <= '0;
        end else if (busy_q && tick) begin
            if (bcnt_q == div) begin
                bcnt_q <= '0;
                if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                    busy_q <= 1'b0;
                    txd_q  <= 1'b1;
                end else begin
                    txd_q   <= shreg_q[0];
                    shreg_q <= {1'b1, shreg_q[DATA_W:1]};
                    idx_q   <= idx_q + IDX_W'(1);
                end
            end else begin
                bcnt_q <= bcnt_q + DIV_W'(1);
            end
        end
    end

    // Checker: counts prescaler ticks over a frame to confirm its length.
    logic [31:0] chk_ticks_q;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            chk_ticks_q <= '0;
        end else if (busy_q && tick) begin
            chk_ticks_q <= chk_ticks_q + 32'd1;
        end
    end

    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !txd_q);

    assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && en) |-> (chk_ticks_q == 32'(FRAME_BITS) * (32'(div) + 32'd1)));

    assert_busy_ignores_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && en && !tick) |=> (busy_q && $stable(idx_q)));

endmodule

// File: rtl/serial_rx_path.sv
// Module: 8N1 receiver. It synchronizes rxd and restarts its half-rate prescaler at the start
// edge. It samples the start bit after (div+1) half-ticks and every later bit after 2*(div+1).
// Assumes the prescaler it drives through restart gives ticks at half the bit-clock ratio.
module serial_rx_path
    import serial_port_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rxd,
    input  logic [DIV_W-1:0]  div,
    input  logic              htick,
    input  logic              rd_clr,
    output logic              restart,
    output logic [DATA_W-1:0] byte_out,
    output logic              avail
);

    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t         state_q;
    logic              rx_m_q, rx_s_q;
    logic [DIV_W:0]    hcnt_q;
    logic [DIV_W:0]    target;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] byte_q;
    logic              avail_q;

    assign restart  = en && (state_q == RX_IDLE) && !rx_s_q;
    assign target   = (state_q == RX_START) ? {1'b0, div} : {div, 1'b1};
    assign byte_out = byte_q;
    assign avail    = avail_q;

    // Two-flop synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m_q <= 1'b1;
            rx_s_q <= 1'b1;
        end else begin
            rx_m_q <= rxd;
            rx_s_q <= rx_m_q;
        end
    end

    // Receive sequencer: finds the start, samples at mid-bit and stores the byte when the stop bit is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            hcnt_q  <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            byte_q  <= '0;
            avail_q <= 1'b0;
        end else begin
            if (rd_clr) begin
                avail_q <= 1'b0;
            end
            if (!en) begin
                state_q <= RX_IDLE;
                hcnt_q  <= '0;
            end else begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rx_s_q) begin
                            state_q <= RX_START;
                            hcnt_q  <= '0;
                        end
                    end
                    default: begin
                        if (htick) begin
                            if (hcnt_q == target) begin
                                hcnt_q <= '0;
                                case (state_q)
                                    RX_START: begin
                                        state_q <= rx_s_q ? RX_IDLE : RX_DATA;
                                        idx_q   <= '0;
                                    end
                                    RX_DATA: begin
                                        shreg_q <= {rx_s_q, shreg_q[DATA_W-1:1]};
                                        if (idx_q == IDX_W'(DATA_W - 1)) begin
                                            state_q <= RX_STOP;
                                        end else begin
                                            idx_q <= idx_q + IDX_W'(1);
                                        end
                                    end
                                    default: begin
                                        if (rx_s_q) begin
                                            byte_q  <= shreg_q;
                                            avail_q <= 1'b1;
                                        end
                                        state_q <= RX_IDLE;
                                    end
                                endcase
                            end else begin
                                hcnt_q <= hcnt_q + (DIV_W+1)'(1);
                            end
                        end
                    end
                endcase
            end
        end
    end

    assert_avail_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_q) |-> ($past(state_q) == RX_STOP && $past(rx_s_q)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && state_q != RX_STOP) |=> !avail_q);

endmodule

// File: rtl/serial_port.sv
// Module: top of the serial port. It holds the control word, decodes register accesses and
// connects one prescaler per direction to the transmit and receive paths.
// Assumes a single-cycle register strobe. Reads are combinational on addr.
module serial_port
    import serial_port_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        rxd,
    output logic        txd
);

    localparam int SEL_LO = 1;
    localparam int SEL_HI = SEL_LO + SEL_W - 1;
    localparam int DIV_LO = SEL_HI + 1;
    localparam int DIV_HI = DIV_LO + DIV_W - 1;
    localparam int AVAIL_BIT = 30;
    localparam int BUSY_BIT  = 31;

    logic              en_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_tick, rx_htick;
    logic              tx_accept, rx_restart;
    logic              tx_busy, rx_avail;
    logic [DATA_W-1:0] rx_byte;
    logic [31:0]       ctrl_rd;
    logic              data_wr, data_rd;

    assign data_wr = wr_en && addr;
    assign data_rd = rd_en && addr;

    // Control word register: enable, coarse select and fine divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
            div_q <= '0;
        end else if (wr_en && !addr) begin
            en_q  <= wdata[0];
            sel_q <= wdata[SEL_HI:SEL_LO];
            div_q <= wdata[DIV_HI:DIV_LO];
        end
    end

    // Read mux: packs the status flags and the fields into the selected word.
    always_comb begin
        ctrl_rd                  = '0;
        ctrl_rd[0]               = en_q;
        ctrl_rd[SEL_HI:SEL_LO]   = sel_q;
        ctrl_rd[DIV_HI:DIV_LO]   = div_q;
        ctrl_rd[AVAIL_BIT]       = rx_avail;
        ctrl_rd[BUSY_BIT]        = tx_busy;
        rdata = addr ? {{(32-DATA_W){1'b0}}, rx_byte} : ctrl_rd;
    end

    baud_prescaler #(.CNT_W(CNT_W), .HALF(1'b0)) u_tx_pre (
        .clk(clk), .rst_n(rst_n), .en(en_q), .restart(tx_accept),
        .sel(sel_q), .tick(tx_tick)
    );

    baud_prescaler #(.CNT_W(CNT_W), .HALF(1'b1)) u_rx_pre (
        .clk(clk), .rst_n(rst_n), .en(en_q), .restart(rx_restart),
        .sel(sel_q), .tick(rx_htick)
    );

    serial_tx_path #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en_q), .start(data_wr),
        .byte_in(wdata[DATA_W-1:0]), .div(div_q), .tick(tx_tick),
        .accept(tx_accept), .txd(txd), .busy(tx_busy)
    );

    serial_rx_path #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en_q), .rxd(rxd), .div(div_q),
        .htick(rx_htick), .rd_clr(data_rd), .restart(rx_restart),
        .byte_out(rx_byte), .avail(rx_avail)
    );

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (txd && !tx_busy));

    assert_disabled_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tx_busy) |=> !tx_busy);

endmodule

// File: tb/serial_port_tb.sv
module serial_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txd;
    logic        loop = 1'b0;
    logic        rx_drv = 1'b1;
    logic        rxd;
    logic        done = 1'b0;
    int          checks = 0;
    int          errors = 0;

    assign rxd = loop ? txd : rx_drv;

    always #4 clk = ~clk;

    serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
    );

    // {select, divider, byte}
    localparam logic [22:0] VEC [9] = '{
        {3'd0, 12'd7,  8'hA5},
        {3'd1, 12'd3,  8'h3C},
        {3'd2, 12'd1,  8'h01},
        {3'd3, 12'd0,  8'h80},
        {3'd0, 12'd15, 8'hFF},
        {3'd4, 12'd1,  8'h5A},
        {3'd5, 12'd0,  8'h00},
        {3'd6, 12'd0,  8'h96},
        {3'd7, 12'd0,  8'h69}
    };

    function automatic int ratio(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 128;
            3'd5: return 1024;
            3'd6: return 2048;
            default: return 4096;
        endcase
    endfunction

    function automatic logic [31:0] cfg(input logic en, input logic [2:0] s, input logic [11:0] d);
        return {16'd0, d, s, en};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 1'b0;
    endtask

    // Samples a frame mid-bit, starting `used` negedges after the write edge, then checks busy and the loopback byte.
    task automatic tx_frame(input logic [7:0] b, input int p, input int used, input logic [31:0] c);
        logic [31:0] r;
        logic exp;
        repeat (p/2 - used) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            exp = (i == 0) ? 1'b0 : ((i == 9) ? 1'b1 : b[i-1]);
            check(txd == exp, "R4 R3 bit value at mid-bit", {31'd0, txd}, {31'd0, exp});
            check(rdata[31] == 1'b1, "R5 busy during frame", rdata, 32'h8000_0000);
            if (i < 9) repeat (p) @(negedge clk);
        end
        repeat (p/2 - 1) @(negedge clk);
        check(rdata[31] == 1'b1, "R5 busy in last cycle", rdata, 32'h8000_0000);
        @(negedge clk);
        check(rdata[31] == 1'b0 && txd == 1'b1, "R5 busy low after 10 periods", {rdata[31], 30'd0, txd}, 32'h1);
        rd_reg(1'b0, r);
        check(r == (c | 32'h4000_0000), "R7 R11 avail and fields", r, c | 32'h4000_0000);
        rd_reg(1'b1, r);
        check(r == {24'd0, b}, "R8 received byte", r, {24'd0, b});
        rd_reg(1'b0, r);
        check(r[30] == 1'b0, "R8 avail cleared by read", r, c);
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic stop, input int p);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_drv = (i == 0) ? 1'b0 : ((i == 9) ? stop : b[i-1]);
            repeat (p - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_drv = 1'b1;
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] c;
        bit stayed;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check(rdata == 32'd0, "R1 control after reset", rdata, 32'd0);
        check(txd == 1'b1, "R1 line idle high", {31'd0, txd}, 32'd1);
        rd_reg(1'b1, r);
        check(r == 32'd0, "R1 data after reset", r, 32'd0);

        // R2: disabled unit ignores data writes and the receive line
        wr_reg(1'b0, cfg(1'b0, 3'd0, 12'd7));
        wr_reg(1'b1, 32'h55);
        stayed = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd != 1'b1 || rdata[31]) stayed = 0;
        end
        check(stayed, "R2 write ignored while disabled", {31'd0, stayed}, 32'd1);
        drive_frame(8'h33, 1'b1, 16);
        repeat (20) @(negedge clk);
        rd_reg(1'b0, r);
        check(r[30] == 1'b0, "R2 receive ignored while disabled", r, cfg(1'b0, 3'd0, 12'd7));

        // Vector table: loopback over all select codes (R3 R4 R5 R7 R8 R11)
        loop = 1'b1;
        for (int v = 0; v < 9; v++) begin
            logic [2:0]  s;
            logic [11:0] d;
            logic [7:0]  b;
            int p;
            {s, d, b} = VEC[v];
            p = ratio(s) * (int'(d) + 1);
            c = cfg(1'b1, s, d);
            wr_reg(1'b0, c);
            repeat (4) @(negedge clk);
            wr_reg(1'b1, {24'd0, b});
            tx_frame(b, p, 0, c);
        end

        // R6: write during busy is ignored
        c = cfg(1'b1, 3'd0, 12'd7);
        wr_reg(1'b0, c);
        repeat (4) @(negedge clk);
        wr_reg(1'b1, 32'hC3);
        wr_reg(1'b1, 32'h3C);
        tx_frame(8'hC3, 16, 2, c);
        repeat (40) @(negedge clk);
        check(txd == 1'b1 && rdata[31] == 1'b0, "R6 no second frame", {rdata[31], 30'd0, txd}, 32'h1);

        // R7 R9: bench-driven receive frames
        loop = 1'b0;
        drive_frame(8'h4E, 1'b1, 16);
        repeat (4) @(negedge clk);
        rd_reg(1'b0, r);
        check(r[30] == 1'b1, "R7 avail after clean frame", r, c | 32'h4000_0000);
        rd_reg(1'b1, r);
        check(r == 32'h4E, "R7 received byte from line", r, 32'h4E);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (3) @(negedge clk);
        rx_drv = 1'b1;
        repeat (200) @(negedge clk);
        rd_reg(1'b0, r);
        check(r[30] == 1'b0, "R9 short glitch rejected", r, c);
        drive_frame(8'hAA, 1'b0, 16);
        repeat (64) @(negedge clk);
        rd_reg(1'b0, r);
        check(r[30] == 1'b0, "R9 low stop bit discarded", r, c);

        // R10: disable mid-frame, both directions
        loop = 1'b1;
        wr_reg(1'b1, 32'h00);
        repeat (30) @(negedge clk);
        wr_reg(1'b0, cfg(1'b0, 3'd0, 12'd7));
        @(negedge clk);
        check(txd == 1'b1 && rdata[31] == 1'b0, "R10 line high and idle after disable", {rdata[31], 30'd0, txd}, 32'h1);
        repeat (200) @(negedge clk);
        rd_reg(1'b0, r);
        check(r == cfg(1'b0, 3'd0, 12'd7), "R10 R11 receive dropped and fields kept", r, cfg(1'b0, 3'd0, 12'd7));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule